// File: doc/BRIEF.md
# DDR2 Command Decoder and Protocol Checker

This block watches the control pins of a DDR2 memory interface and turns every clock cycle into exactly one command. The pins are chip select, the row strobe, the column strobe, the write enable (all four active low), the clock enable, the bank address and address bit 10. A register holds the clock enable from the previous cycle. The decoder uses that stored level together with the current one to separate auto refresh from self-refresh entry, and to recognise entry into and exit from power-down.

Each result is registered. The command code, the bank, an auto-precharge flag, the low-power state and a violation flag appear on the outputs after the clock edge that sampled the pins. The violation flag marks pin patterns that are not legal in the current clock-enable context. It also marks a read or write that arrives while a 4-beat burst is still using the bus. The block is passive and is meant to sit beside a memory controller or a bus model as a protocol monitor.

Top module: `ddr2_cmd_monitor`

## Requirements
- R1: An active-low asynchronous reset sets cmd_o to the deselect code, bank_o, ap_o and viol_o to 0, and lp_o to idle (0). It also clears the stored clock enable to low and empties the burst window. The first cycle after reset with cke_i low therefore reports a hold, and the first read after reset is not flagged.
- R2: cmd_o is one-hot and carries the decode of the pins sampled at the previous rising edge. The bit positions are: 0 deselect, 1 NOP, 2 activate, 3 precharge one bank, 4 precharge all, 5 write, 6 write with auto-precharge, 7 read, 8 read with auto-precharge, 9 mode register set, 10 auto refresh, 11 self-refresh entry, 12 power-down entry, 13 low-power exit, 14 low-power hold, 15 illegal.
- R3: When the clock enable is high in both the previous and the current cycle, cs_ni high decodes as deselect. cs_ni low with ras_ni, cas_ni and we_ni all high decodes as NOP.
- R4: When the clock enable is high in both cycles and cs_ni is low, the strobe patterns ras/cas/we decode as follows: 0,1,1 is activate, 0,0,0 is mode register set, and 0,0,1 is auto refresh. bank_o carries ba_i for activate and mode register set, and is 0 for refresh.
- R5: The pattern 0,1,0 decodes as precharge. With a10_i low it is a single-bank precharge and bank_o = ba_i. With a10_i high it is precharge-all and bank_o = 0 whatever ba_i holds.
- R6: The pattern 1,0,0 is a write and 1,0,1 is a read, with bank_o = ba_i. a10_i high selects the auto-precharge variant and sets ap_o. ap_o is 0 for every other command.
- R7: Three cases decode as illegal and set viol_o: the pattern 1,1,0 with the clock enable high in both cycles; a clock-enable rise with anything other than deselect or NOP; and a clock-enable fall with anything other than deselect, NOP or the refresh pattern.
- R8: A clock-enable fall (previous high, current low) with deselect or NOP decodes as power-down entry, and lp_o becomes 1.
- R9: A clock-enable fall with cs_ni low and pattern 0,0,1 decodes as self-refresh entry, and lp_o becomes 2.
- R10: When the clock enable is low in both cycles, the cycle decodes as low-power hold whatever the other pins show, and lp_o keeps its value.
- R11: A clock-enable rise with deselect or NOP decodes as low-power exit. After any clock-enable rise, lp_o returns to idle (0), even when the cycle is flagged illegal.
- R12: With burst length 4, a read or write that is decoded in the cycle right after a read or write sets viol_o and still reports its command. A flagged access restarts the burst window. A read or write two or more cycles after the last one is not flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; pins sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable pin |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | BANK_W | Bank address |
| a10_i | input | 1 | Address bit 10 (all-banks / auto-precharge select) |
| cmd_o | output | 16 | One-hot command code |
| bank_o | output | BANK_W | Bank of the decoded command, 0 where no bank applies |
| ap_o | output | 1 | Auto-precharge variant of read or write |
| lp_o | output | 2 | Low-power state: 0 idle, 1 power-down, 2 self-refresh |
| viol_o | output | 1 | Protocol violation for the reported cycle |

## Verification
The properties assume that every control pin has a defined 0 or 1 value at each rising edge. They also assume that reset is held across at least one edge, so the stored clock enable and the burst window start from a known state. The bench changes pins only just after the falling edge and never lets them float. In its random phase it keeps the clock enable high most of the time, so that long stretches of normal commands, back-to-back accesses and low-power entries and exits all occur.

// File: rtl/ddr2_cmd_pkg.sv
package ddr2_cmd_pkg;
  localparam int IDX_W = 4;
  localparam int NCMD  = 1 << IDX_W;

  typedef logic [IDX_W-1:0] cmd_idx_t;

  localparam cmd_idx_t CI_DESEL = 4'd0;
  localparam cmd_idx_t CI_NOP   = 4'd1;
  localparam cmd_idx_t CI_ACT   = 4'd2;
  localparam cmd_idx_t CI_PRE   = 4'd3;
  localparam cmd_idx_t CI_PREA  = 4'd4;
  localparam cmd_idx_t CI_WR    = 4'd5;
  localparam cmd_idx_t CI_WRA   = 4'd6;
  localparam cmd_idx_t CI_RD    = 4'd7;
  localparam cmd_idx_t CI_RDA   = 4'd8;
  localparam cmd_idx_t CI_MRS   = 4'd9;
  localparam cmd_idx_t CI_REF   = 4'd10;
  localparam cmd_idx_t CI_SRE   = 4'd11;
  localparam cmd_idx_t CI_PDE   = 4'd12;
  localparam cmd_idx_t CI_LPX   = 4'd13;
  localparam cmd_idx_t CI_HOLD  = 4'd14;
  localparam cmd_idx_t CI_ILL   = 4'd15;

  typedef enum logic [1:0] {
    LP_IDLE = 2'd0,
    LP_PDN  = 2'd1,
    LP_SREF = 2'd2
  } lp_state_e;
endpackage

// File: rtl/ddr2_pin_decode.sv
module ddr2_pin_decode
  import ddr2_cmd_pkg::*;
(
  input  logic     cke_prev_i,
  input  logic     cke_now_i,
  input  logic     cs_n_i,
  input  logic     ras_n_i,
  input  logic     cas_n_i,
  input  logic     we_n_i,
  input  logic     a10_i,
  output cmd_idx_t idx_o
);
  logic [2:0] rcw;
  logic       quiet;

  assign rcw   = {ras_n_i, cas_n_i, we_n_i};
  assign quiet = cs_n_i | (rcw == 3'b111);

  always_comb begin
    idx_o = CI_ILL;
    case ({cke_prev_i, cke_now_i})
      2'b00: idx_o = CI_HOLD;
      2'b01: idx_o = quiet ? CI_LPX : CI_ILL;
      2'b10: begin
        if (quiet)                         idx_o = CI_PDE;
        else if (rcw == 3'b001)            idx_o = CI_SRE;
        else                               idx_o = CI_ILL;
      end
      default: begin
        if (cs_n_i) idx_o = CI_DESEL;
        else begin
          case (rcw)
            3'b111:  idx_o = CI_NOP;
            3'b011:  idx_o = CI_ACT;
            3'b010:  idx_o = a10_i ? CI_PREA : CI_PRE;
            3'b100:  idx_o = a10_i ? CI_WRA : CI_WR;
            3'b101:  idx_o = a10_i ? CI_RDA : CI_RD;
            3'b000:  idx_o = CI_MRS;
            3'b001:  idx_o = CI_REF;
            default: idx_o = CI_ILL;
          endcase
        end
      end
    endcase
  end
endmodule

// File: rtl/ddr2_lp_track.sv
module ddr2_lp_track
  import ddr2_cmd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cke_i,
  input  cmd_idx_t  idx_i,
  output logic      cke_q_o,
  output lp_state_e lp_o
);
  lp_state_e lp_d;

  always_comb begin
    lp_d = lp_o;
    if (!cke_q_o && cke_i) lp_d = LP_IDLE;
    if (idx_i == CI_SRE)      lp_d = LP_SREF;
    else if (idx_i == CI_PDE) lp_d = LP_PDN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q_o <= 1'b0;
      lp_o    <= LP_IDLE;
    end else begin
      cke_q_o <= cke_i;
      lp_o    <= lp_d;
    end
  end
endmodule

// File: rtl/ddr2_burst_guard.sv
module ddr2_burst_guard #(
  parameter int BURST_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rw_i,
  output logic collide_o
);
  // two beats per clock: a burst keeps the bus for BURST_LEN/2 cycles
  localparam int BUSY  = BURST_LEN / 2 - 1;
  localparam int CNT_W = $clog2(BURST_LEN);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy;

  assign busy      = (cnt_q != '0);
  assign collide_o = rw_i & busy;

  always_comb begin
    if (rw_i)      cnt_d = LOAD;
    else if (busy) cnt_d = cnt_q - 1'b1;
    else           cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ddr2_cmd_monitor.sv
module ddr2_cmd_monitor
  import ddr2_cmd_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int BURST_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [BANK_W-1:0] ba_i,
  input  logic              a10_i,
  output logic [NCMD-1:0]   cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              ap_o,
  output logic [1:0]        lp_o,
  output logic              viol_o
);
  cmd_idx_t        idx;
  logic            cke_q;
  logic            collide;
  logic            is_rw, uses_bank, is_ap;
  logic [NCMD-1:0] oh;
  lp_state_e       lp_state;

  ddr2_pin_decode u_dec (
    .cke_prev_i (cke_q),
    .cke_now_i  (cke_i),
    .cs_n_i     (cs_ni),
    .ras_n_i    (ras_ni),
    .cas_n_i    (cas_ni),
    .we_n_i     (we_ni),
    .a10_i      (a10_i),
    .idx_o      (idx)
  );

  ddr2_lp_track u_lp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cke_i   (cke_i),
    .idx_i   (idx),
    .cke_q_o (cke_q),
    .lp_o    (lp_state)
  );

  ddr2_burst_guard #(.BURST_LEN(BURST_LEN)) u_burst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rw_i      (is_rw),
    .collide_o (collide)
  );

  for (genvar g = 0; g < NCMD; g++) begin : g_oh
    assign oh[g] = (idx == cmd_idx_t'(g));
  end

  assign is_rw     = oh[CI_WR] | oh[CI_WRA] | oh[CI_RD] | oh[CI_RDA];
  assign is_ap     = oh[CI_WRA] | oh[CI_RDA];
  assign uses_bank = is_rw | oh[CI_ACT] | oh[CI_PRE] | oh[CI_MRS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o  <= NCMD'(1) << CI_DESEL;
      bank_o <= '0;
      ap_o   <= 1'b0;
      viol_o <= 1'b0;
    end else begin
      cmd_o  <= oh;
      bank_o <= uses_bank ? ba_i : '0;
      ap_o   <= is_ap;
      viol_o <= oh[CI_ILL] | collide;
    end
  end

  assign lp_o = lp_state;
endmodule

// File: rtl/ddr2_cmd_monitor_chk.sv
module ddr2_cmd_monitor_chk
  import ddr2_cmd_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NCMD-1:0]   cmd_o,
  input logic [BANK_W-1:0] bank_o,
  input logic              ap_o,
  input logic [1:0]        lp_o,
  input logic              viol_o
);
  localparam logic [NCMD-1:0] RW_MASK = (NCMD'(1) << CI_WR) | (NCMD'(1) << CI_WRA) |
                                        (NCMD'(1) << CI_RD) | (NCMD'(1) << CI_RDA);

  // R2
  cmd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cmd_o) == 1);

  // R5
  prea_nobank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[CI_PREA] |-> bank_o == '0);

  // R6
  ap_only_rw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_o |-> (cmd_o[CI_WRA] | cmd_o[CI_RDA]));

  // R7
  illegal_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[CI_ILL] |-> viol_o);

  // R8
  pde_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[CI_PDE] |-> lp_o == LP_PDN);

  // R9
  sre_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[CI_SRE] |-> lp_o == LP_SREF);

  // R10
  hold_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[CI_HOLD] |-> $stable(lp_o));

  // R11
  exit_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[CI_LPX] |-> lp_o == LP_IDLE);

  // R12
  burst_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_o & RW_MASK) != '0) |=> (((cmd_o & RW_MASK) != '0) -> viol_o));
endmodule

bind ddr2_cmd_monitor ddr2_cmd_monitor_chk #(.BANK_W(BANK_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cmd_o  (cmd_o),
  .bank_o (bank_o),
  .ap_o   (ap_o),
  .lp_o   (lp_o),
  .viol_o (viol_o)
);

// File: tb/ddr2_cmd_monitor_test.sv
module ddr2_cmd_monitor_test;
  localparam int CLK_PERIOD = 10;

  // command bit positions, per R2
  localparam int K_DESEL = 0, K_NOP = 1, K_ACT = 2, K_PRE = 3, K_PREA = 4;
  localparam int K_WR = 5, K_WRA = 6, K_RD = 7, K_RDA = 8, K_MRS = 9, K_REF = 10;
  localparam int K_SRE = 11, K_PDE = 12, K_LPX = 13, K_HOLD = 14, K_ILL = 15;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cke_i = 1'b0, cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic [1:0]  ba_i = 2'd0;
  logic        a10_i = 1'b0;
  logic [15:0] cmd_o;
  logic [1:0]  bank_o;
  logic        ap_o;
  logic [1:0]  lp_o;
  logic        viol_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit m_cke = 0;
  int m_lp  = 0;
  int m_gap = 1000;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ddr2_cmd_monitor uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i), .cs_ni(cs_ni), .ras_ni(ras_ni),
    .cas_ni(cas_ni), .we_ni(we_ni), .ba_i(ba_i), .a10_i(a10_i), .cmd_o(cmd_o),
    .bank_o(bank_o), .ap_o(ap_o), .lp_o(lp_o), .viol_o(viol_o)
  );

  function automatic int ref_cmd(bit pc, bit cc, bit cs, bit r, bit c, bit w, bit a10);
    bit quiet = cs || (r && c && w);
    if (!pc && !cc) return K_HOLD;
    if (!pc && cc)  return quiet ? K_LPX : K_ILL;
    if (pc && !cc) begin
      if (quiet) return K_PDE;
      if (!r && !c && w) return K_SRE;
      return K_ILL;
    end
    if (cs) return K_DESEL;
    if (r && c && w)    return K_NOP;
    if (!r && c && w)   return K_ACT;
    if (!r && c && !w)  return a10 ? K_PREA : K_PRE;
    if (r && !c && !w)  return a10 ? K_WRA : K_WR;
    if (r && !c && w)   return a10 ? K_RDA : K_RD;
    if (!r && !c && !w) return K_MRS;
    if (!r && !c && w)  return K_REF;
    return K_ILL;
  endfunction

  task automatic step(input bit cke, input bit cs, input bit r, input bit c, input bit w,
                      input logic [1:0] ba, input bit a10, input string req);
    int          k;
    bit          rw, e_ap, e_viol;
    logic [1:0]  e_bank;
    logic [15:0] e_cmd;
    cke_i = cke; cs_ni = cs; ras_ni = r; cas_ni = c; we_ni = w; ba_i = ba; a10_i = a10;
    k      = ref_cmd(m_cke, cke, cs, r, c, w, a10);
    rw     = (k == K_WR) || (k == K_WRA) || (k == K_RD) || (k == K_RDA);
    e_cmd  = 16'(1) << k;
    e_ap   = (k == K_WRA) || (k == K_RDA);
    e_bank = (rw || k == K_ACT || k == K_PRE || k == K_MRS) ? ba : 2'd0;
    e_viol = (k == K_ILL) || (rw && m_gap < 2);
    m_gap  = rw ? 1 : (m_gap < 1000 ? m_gap + 1 : m_gap);
    if (!m_cke && cke) m_lp = 0;
    if (k == K_SRE) m_lp = 2;
    else if (k == K_PDE) m_lp = 1;
    m_cke = cke;
    @(negedge clk_i);
    checks++;
    if (cmd_o !== e_cmd || bank_o !== e_bank || ap_o !== e_ap ||
        lp_o !== 2'(m_lp) || viol_o !== e_viol) begin
      errors++;
      $display("FAIL %s: cmd=%h bank=%0d ap=%b lp=%0d viol=%b expected cmd=%h bank=%0d ap=%b lp=%0d viol=%b",
               req, cmd_o, bank_o, ap_o, lp_o, viol_o, e_cmd, e_bank, e_ap, m_lp, e_viol);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset values
    checks++;
    if (cmd_o !== 16'h0001 || bank_o !== 2'd0 || ap_o !== 1'b0 || lp_o !== 2'd0 || viol_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: cmd=%h bank=%0d ap=%b lp=%0d viol=%b expected cmd=0001 bank=0 ap=0 lp=0 viol=0",
               cmd_o, bank_o, ap_o, lp_o, viol_o);
    end
    rst_ni = 1'b1;

    step(0, 1, 1, 1, 1, 2'd0, 0, "R1");        // stored CKE low -> hold
    step(1, 0, 1, 1, 1, 2'd0, 0, "R11");       // rise with NOP -> exit
    step(1, 1, 0, 0, 0, 2'd3, 1, "R3");        // deselect
    step(1, 0, 1, 1, 1, 2'd2, 0, "R3");        // NOP
    step(1, 0, 0, 1, 1, 2'd2, 0, "R4");        // activate
    step(1, 0, 0, 0, 0, 2'd1, 0, "R4");        // mode register
    step(1, 0, 0, 0, 1, 2'd3, 0, "R4");        // refresh, no bank
    step(1, 0, 0, 1, 0, 2'd3, 0, "R5");        // single precharge
    step(1, 0, 0, 1, 0, 2'd2, 1, "R5");        // precharge all
    step(1, 0, 1, 0, 0, 2'd1, 0, "R6");        // write
    step(1, 0, 1, 1, 1, 2'd0, 0, "R6");
    step(1, 0, 1, 1, 1, 2'd0, 0, "R6");
    step(1, 0, 1, 0, 1, 2'd0, 1, "R6");        // read with AP
    step(1, 0, 1, 1, 1, 2'd0, 0, "R12");
    step(1, 0, 1, 0, 0, 2'd1, 1, "R6");        // write with AP, gap 2
    step(1, 0, 1, 0, 1, 2'd2, 0, "R12");       // read right after -> violation
    step(1, 0, 1, 0, 1, 2'd3, 0, "R12");       // again -> window restarted
    step(1, 1, 1, 1, 1, 2'd0, 0, "R12");
    step(1, 0, 1, 0, 1, 2'd0, 0, "R12");       // gap 2 -> clean
    step(1, 0, 1, 1, 0, 2'd0, 0, "R7");        // 1,1,0 illegal
    step(0, 1, 0, 0, 0, 2'd0, 0, "R8");        // power-down entry
    step(0, 0, 0, 1, 1, 2'd1, 1, "R10");       // hold with busy pins
    step(0, 0, 1, 0, 1, 2'd2, 0, "R10");
    step(1, 1, 1, 1, 1, 2'd0, 0, "R11");       // exit
    step(0, 0, 0, 0, 1, 2'd0, 0, "R9");        // self-refresh entry
    step(0, 1, 1, 1, 1, 2'd0, 0, "R10");
    step(1, 0, 0, 1, 1, 2'd1, 0, "R7");        // rise with activate -> illegal, idle
    step(1, 0, 1, 1, 1, 2'd0, 0, "R11");
    step(0, 0, 1, 0, 1, 2'd0, 0, "R7");        // fall with read -> illegal
    step(0, 1, 1, 1, 1, 2'd0, 0, "R10");
    step(1, 0, 1, 1, 1, 2'd0, 0, "R11");

    for (int i = 0; i < 400; i++) begin
      bit nc;
      nc = m_cke ? ($urandom % 10 != 0) : ($urandom % 3 != 0);
      step(nc, ($urandom % 4) == 0, 1'($urandom), 1'($urandom), 1'($urandom),
           2'($urandom), 1'($urandom), "R2");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule